// File: doc/BRIEF.md
# Register-Mapped GPIO Bridge for Flash Strobes and a Serial Sensor

This block is a word-addressed register file with two GPIO ports, A and D. Each port has a data-out register, an output-enable register and a read-only data-in view. Three bits of the port-A data-out register drive the latch and select strobes of a NAND flash. The flash's ready/busy line is merged into the port-A data-in view.

Port D is used to bit-bang a serial temperature sensor. A bus write that flips the port-D clock bit raises a one-cycle edge event in the same cycle. The event carries the new clock level and the serial data bit taken from the written word. The sensor's serial output is merged into the port-D data-in view.

The bus side is a simple request interface controlled by a two-state machine.
- **IDLE**: `bus_ready` is high. A write completes in the cycle it is presented and the machine stays in IDLE. A read moves the machine to RDRESP (transition *read-accept*).
- **RDRESP**: `bus_rvalid` is high, `bus_ready` is low and the captured word is on `bus_rdata`. The machine then returns to IDLE unconditionally (transition *response-done*).

Only aligned 32-bit words inside the 0x5C-byte window are valid accesses.

Top module: `gpio_bitbang_bridge`

## Requirements
- R1: After reset every register reads zero, `bus_rdata` is zero, `bus_ready` is 1, `bus_rvalid` is 0, and all NAND strobes and `sns_edge` are 0.
- R2: The word index is the byte address shifted right by two. An access whose byte address has nonzero bits [1:0], or is 0x5C or above, has no effect when written. Such an access reads back zero and is still answered with `bus_rvalid`.
- R3: A read is accepted in IDLE. `bus_rvalid` is high for exactly the following cycle, with `bus_ready` low, and the machine is back in IDLE one cycle later.
- R4: Reading byte address 0x04 (port-A data-in) returns port-A data-out (0x00) ANDed with port-A enable (0x08). Bit 7 of the result is additionally ORed with `nand_rdy` as sampled in the accepting cycle.
- R5: Reading byte address 0x44 (port-D data-in) returns port-D data-out (0x40) ANDed with port-D enable (0x48). Bit 4 of the result is additionally ORed with `sns_sdi` as sampled in the accepting cycle.
- R6: From the cycle after a write to port-A data-out, `nand_ale` follows bit 6 of that register, `nand_cle` follows bit 5 and `nand_ce` follows bit 4.
- R7: A write to port-D data-out whose bit 1 differs from the stored bit 1 raises `sns_edge` for that single cycle. In that cycle `sns_level` equals the written bit 1 and `sns_sdo` equals the written bit 4. A write that leaves bit 1 unchanged raises no event.
- R8: All other word offsets in the window (data-out, enable, and spare words such as 0x20 and 0x58) read back the last value written.
- R9: Writes to the data-in addresses 0x04 and 0x44 are ignored.
- R10: Writes complete in a single cycle without lowering `bus_ready`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | Byte address |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_ready | output | 1 | Request is accepted this cycle |
| bus_rvalid | output | 1 | Read data valid |
| bus_rdata | output | DATA_W (32) | Read data |
| nand_ale | output | 1 | Flash address-latch enable |
| nand_cle | output | 1 | Flash command-latch enable |
| nand_ce | output | 1 | Flash chip enable |
| nand_rdy | input | 1 | Flash ready/busy line |
| sns_edge | output | 1 | Sensor clock-edge event pulse |
| sns_level | output | 1 | New sensor clock level for the event |
| sns_sdo | output | 1 | Serial data toward the sensor |
| sns_sdi | input | 1 | Serial data from the sensor |

## Verification
The faults that matter here show up at the ports within a cycle or two.

A state register stuck in RDRESP would hold `bus_ready` low on the very next cycle. One stuck in IDLE would never raise `bus_rvalid` after a read. A wrong word decode or a lost write shows up on the next read of that offset. It also appears one cycle after the write on the NAND strobes.

A stale copy of the port-D clock bit produces a missing or spurious `sns_edge` in the same cycle as the next write to port-D data-out. The bench therefore predicts every event from its own model of that bit.

// File: rtl/gpio_bb_pkg.sv
package gpio_bb_pkg;

    // Word indices (byte address >> 2) whose meaning the logic decodes
    localparam int IDX_PA_DOUT = 0;
    localparam int IDX_PA_DIN  = 1;
    localparam int IDX_PA_OE   = 2;
    localparam int IDX_PD_DOUT = 16;
    localparam int IDX_PD_DIN  = 17;
    localparam int IDX_PD_OE   = 18;

    // Bit positions used by neighbouring devices
    localparam int PA_RDY_BIT = 7;
    localparam int PA_ALE_BIT = 6;
    localparam int PA_CLE_BIT = 5;
    localparam int PA_CE_BIT  = 4;
    localparam int PD_SCK_BIT = 1;
    localparam int PD_SDO_BIT = 4;
    localparam int PD_SDI_BIT = 4;

    typedef enum logic {
        BUS_IDLE   = 1'b0,
        BUS_RDRESP = 1'b1
    } bus_state_e;

endpackage

// File: rtl/gpio_bb_regfile.sv
module gpio_bb_regfile
    import gpio_bb_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NWORDS = 23,
    parameter int IDX_W  = 5
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [IDX_W-1:0]               wr_idx,
    input  logic [DATA_W-1:0]              wr_data,
    output logic [NWORDS-1:0][DATA_W-1:0]  words
);

    for (genvar i = 0; i < NWORDS; i++) begin : g_word
        if (i == IDX_PA_DIN || i == IDX_PD_DIN) begin : g_ro
            // data-in views hold no storage; the read mux composes them
            assign words[i] = '0;
        end else begin : g_rw
            logic [DATA_W-1:0] q;
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= '0;
                else if (wr_en && wr_idx == IDX_W'(i))
                    q <= wr_data;
            end
            assign words[i] = q;
        end
    end

    // R8
    oe_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == IDX_W'(IDX_PA_OE)) |=> (words[IDX_PA_OE] == $past(wr_data)));

endmodule

// File: rtl/gpio_bb_rdmux.sv
module gpio_bb_rdmux
    import gpio_bb_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NWORDS = 23,
    parameter int IDX_W  = 5
) (
    input  logic [NWORDS-1:0][DATA_W-1:0]  words,
    input  logic [IDX_W-1:0]               rd_idx,
    input  logic                           addr_ok,
    input  logic                           nand_rdy,
    input  logic                           sns_sdi,
    output logic [DATA_W-1:0]              rd_word
);

    logic [DATA_W-1:0] pa_view;
    logic [DATA_W-1:0] pd_view;

    always_comb begin
        pa_view = words[IDX_PA_DOUT] & words[IDX_PA_OE];
        pa_view[PA_RDY_BIT] = pa_view[PA_RDY_BIT] | nand_rdy;
        pd_view = words[IDX_PD_DOUT] & words[IDX_PD_OE];
        pd_view[PD_SDI_BIT] = pd_view[PD_SDI_BIT] | sns_sdi;
    end

    always_comb begin
        rd_word = '0;
        if (addr_ok) begin
            if (rd_idx == IDX_W'(IDX_PA_DIN))
                rd_word = pa_view;
            else if (rd_idx == IDX_W'(IDX_PD_DIN))
                rd_word = pd_view;
            else if (int'(rd_idx) < NWORDS)
                rd_word = words[rd_idx];
        end
    end

endmodule

// File: rtl/gpio_bb_sck_edge.sv
module gpio_bb_sck_edge (
    input  logic wr_hit,    // valid write to port-D data-out
    input  logic new_sck,   // written clock bit
    input  logic new_sdo,   // written data bit
    input  logic cur_sck,   // stored clock bit
    output logic evt,
    output logic evt_level,
    output logic evt_sdo
);

    always_comb begin
        evt       = wr_hit && (new_sck != cur_sck);
        evt_level = new_sck;
        evt_sdo   = new_sdo;
    end

endmodule

// File: rtl/gpio_bitbang_bridge.sv
module gpio_bitbang_bridge
    import gpio_bb_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int WIN_BYTES = 92
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              bus_ready,
    output logic              bus_rvalid,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              nand_ale,
    output logic              nand_cle,
    output logic              nand_ce,
    input  logic              nand_rdy,
    output logic              sns_edge,
    output logic              sns_level,
    output logic              sns_sdo,
    input  logic              sns_sdi
);

    localparam int NWORDS = WIN_BYTES / 4;
    localparam int IDX_W  = $clog2(NWORDS);

    bus_state_e state_q, state_d;

    logic [NWORDS-1:0][DATA_W-1:0] words;
    logic [IDX_W-1:0]              word_idx;
    logic                          addr_ok;
    logic                          wr_en;
    logic                          rd_accept;
    logic [DATA_W-1:0]             rd_word;
    logic [DATA_W-1:0]             rdata_q;

    assign word_idx  = bus_addr[2 +: IDX_W];
    assign addr_ok   = (bus_addr[1:0] == 2'b00) && (int'(bus_addr) < WIN_BYTES);
    assign wr_en     = bus_req && bus_we && bus_ready && addr_ok;
    assign rd_accept = bus_req && !bus_we && bus_ready;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= BUS_IDLE;
        else
            state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE:   if (bus_req && !bus_we) state_d = BUS_RDRESP;
            BUS_RDRESP: state_d = BUS_IDLE;
            default:    state_d = BUS_IDLE;
        endcase
    end

    // state outputs
    always_comb begin
        bus_ready  = 1'b0;
        bus_rvalid = 1'b0;
        unique case (state_q)
            BUS_IDLE:   bus_ready  = 1'b1;
            BUS_RDRESP: bus_rvalid = 1'b1;
            default:    bus_ready  = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (rd_accept)
            rdata_q <= rd_word;
    end
    assign bus_rdata = rdata_q;

    gpio_bb_regfile #(
        .DATA_W (DATA_W),
        .NWORDS (NWORDS),
        .IDX_W  (IDX_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (word_idx),
        .wr_data (bus_wdata),
        .words   (words)
    );

    gpio_bb_rdmux #(
        .DATA_W (DATA_W),
        .NWORDS (NWORDS),
        .IDX_W  (IDX_W)
    ) u_rdmux (
        .words    (words),
        .rd_idx   (word_idx),
        .addr_ok  (addr_ok),
        .nand_rdy (nand_rdy),
        .sns_sdi  (sns_sdi),
        .rd_word  (rd_word)
    );

    gpio_bb_sck_edge u_edge (
        .wr_hit    (wr_en && word_idx == IDX_W'(IDX_PD_DOUT)),
        .new_sck   (bus_wdata[PD_SCK_BIT]),
        .new_sdo   (bus_wdata[PD_SDO_BIT]),
        .cur_sck   (words[IDX_PD_DOUT][PD_SCK_BIT]),
        .evt       (sns_edge),
        .evt_level (sns_level),
        .evt_sdo   (sns_sdo)
    );

    assign nand_ale = words[IDX_PA_DOUT][PA_ALE_BIT];
    assign nand_cle = words[IDX_PA_DOUT][PA_CLE_BIT];
    assign nand_ce  = words[IDX_PA_DOUT][PA_CE_BIT];

    // R3
    rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && bus_ready) |=> (bus_rvalid && !bus_ready));

    // R3
    rvalid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |=> (!bus_rvalid && bus_ready));

    // R6
    nand_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && bus_ready && bus_addr == ADDR_W'(4 * IDX_PA_DOUT))
        |=> (nand_ale == $past(bus_wdata[PA_ALE_BIT]) && nand_ce == $past(bus_wdata[PA_CE_BIT])));

    // R7
    edge_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sns_edge |=> (words[IDX_PD_DOUT][PD_SCK_BIT] == $past(sns_level)));

    // R2
    bad_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && !addr_ok) |=> $stable(words));

endmodule

// File: tb/tb_gpio_bitbang_bridge.sv
`timescale 1ns/1ps
module tb_gpio_bitbang_bridge;

    localparam real HALF = 2.5;

    typedef struct packed {
        logic        we;
        logic [7:0]  addr;
        logic [31:0] wd;
        logic        rdy;
        logic        so;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 8'h00, 32'h12345670, 1'b0, 1'b0, 32'h0},
        '{1'b1, 8'h08, 32'h0000FF7F, 1'b0, 1'b0, 32'h0},
        '{1'b0, 8'h04, 32'h0,        1'b0, 1'b0, 32'h00005670}, // R4
        '{1'b0, 8'h04, 32'h0,        1'b1, 1'b0, 32'h000056F0}, // R4
        '{1'b1, 8'h48, 32'h000000EF, 1'b0, 1'b0, 32'h0},
        '{1'b1, 8'h40, 32'hA5A5A5B4, 1'b0, 1'b0, 32'h0},
        '{1'b0, 8'h44, 32'h0,        1'b0, 1'b0, 32'h000000A4}, // R5
        '{1'b0, 8'h44, 32'h0,        1'b0, 1'b1, 32'h000000B4}, // R5
        '{1'b0, 8'h00, 32'h0,        1'b0, 1'b0, 32'h12345670}, // R8
        '{1'b0, 8'h08, 32'h0,        1'b0, 1'b0, 32'h0000FF7F}, // R8
        '{1'b0, 8'h48, 32'h0,        1'b0, 1'b0, 32'h000000EF}, // R8
        '{1'b1, 8'h20, 32'hDEADBEEF, 1'b0, 1'b0, 32'h0},
        '{1'b0, 8'h20, 32'h0,        1'b0, 1'b0, 32'hDEADBEEF}, // R8
        '{1'b1, 8'h58, 32'hCAFEF00D, 1'b0, 1'b0, 32'h0},
        '{1'b0, 8'h58, 32'h0,        1'b0, 1'b0, 32'hCAFEF00D}, // R8
        '{1'b1, 8'h5C, 32'h00000001, 1'b0, 1'b0, 32'h0},
        '{1'b0, 8'h5C, 32'h0,        1'b0, 1'b0, 32'h0},        // R2
        '{1'b1, 8'h02, 32'hFFFFFFFF, 1'b0, 1'b0, 32'h0},
        '{1'b0, 8'h00, 32'h0,        1'b0, 1'b0, 32'h12345670}, // R2
        '{1'b1, 8'h04, 32'hFFFFFFFF, 1'b0, 1'b0, 32'h0},
        '{1'b0, 8'h04, 32'h0,        1'b0, 1'b0, 32'h00005670}  // R9
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ready, bus_rvalid;
    logic [31:0] bus_rdata;
    logic        nand_ale, nand_cle, nand_ce;
    logic        nand_rdy = 1'b0;
    logic        sns_edge, sns_level, sns_sdo;
    logic        sns_sdi = 1'b0;

    int checks = 0;
    int errors = 0;
    logic sck_model = 1'b0;

    always #(HALF) clk = ~clk;

    gpio_bitbang_bridge dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_req    (bus_req),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_ready  (bus_ready),
        .bus_rvalid (bus_rvalid),
        .bus_rdata  (bus_rdata),
        .nand_ale   (nand_ale),
        .nand_cle   (nand_cle),
        .nand_ce    (nand_ce),
        .nand_rdy   (nand_rdy),
        .sns_edge   (sns_edge),
        .sns_level  (sns_level),
        .sns_sdo    (sns_sdo),
        .sns_sdi    (sns_sdi)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [31:0] d);
        bit exp_evt;
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        #1;
        exp_evt = (a == 8'h40) && (d[1] != sck_model);
        chk(sns_edge == exp_evt, "R7 edge", 32'(sns_edge), 32'(exp_evt));
        if (exp_evt) begin
            chk(sns_level == d[1], "R7 level", 32'(sns_level), 32'(d[1]));
            chk(sns_sdo == d[4], "R7 sdo", 32'(sns_sdo), 32'(d[4]));
        end
        chk(bus_ready == 1'b1, "R10 ready", 32'(bus_ready), 32'd1);
        @(posedge clk);
        #1;
        bus_req = 1'b0; bus_we = 1'b0;
        if (a == 8'h40) sck_model = d[1];
    endtask

    task automatic do_read(input logic [7:0] a, input logic rdy, input logic so,
                           input logic [31:0] exp, input string req);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a; nand_rdy = rdy; sns_sdi = so;
        @(posedge clk);
        #1;
        bus_req = 1'b0;
        @(negedge clk);
        chk(bus_rvalid == 1'b1 && bus_ready == 1'b0, "R3 handshake",
            {30'd0, bus_rvalid, bus_ready}, 32'h2);
        chk(bus_rdata == exp, req, bus_rdata, exp);
    endtask

    initial begin
        #(HALF * 2 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        chk(bus_ready == 1'b1 && bus_rvalid == 1'b0, "R1 handshake",
            {30'd0, bus_ready, bus_rvalid}, 32'h2);
        chk(bus_rdata == 32'h0, "R1 rdata", bus_rdata, 32'h0);
        chk({nand_ale, nand_cle, nand_ce, sns_edge} == 4'b0, "R1 pins",
            {28'd0, nand_ale, nand_cle, nand_ce, sns_edge}, 32'h0);
        do_read(8'h00, 1'b0, 1'b0, 32'h0, "R1 pa_dout");
        do_read(8'h48, 1'b0, 1'b0, 32'h0, "R1 pd_oe");

        // R3 return to idle after the response cycle
        @(negedge clk);
        chk(bus_ready == 1'b1 && bus_rvalid == 1'b0, "R3 back to idle",
            {30'd0, bus_ready, bus_rvalid}, 32'h2);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].we)
                do_write(VEC[i].addr, VEC[i].wd);
            else
                do_read(VEC[i].addr, VEC[i].rdy, VEC[i].so, VEC[i].exp,
                        $sformatf("R4/R5/R8/R2/R9 vec %0d", i));
        end

        // R6 strobes: port-A data-out now 0x12345670 -> all three high
        @(negedge clk);
        chk({nand_ale, nand_cle, nand_ce} == 3'b111, "R6 strobes 0x70",
            {29'd0, nand_ale, nand_cle, nand_ce}, 32'h7);
        do_write(8'h00, 32'h00000040);
        @(negedge clk);
        chk({nand_ale, nand_cle, nand_ce} == 3'b100, "R6 ale only",
            {29'd0, nand_ale, nand_cle, nand_ce}, 32'h4);
        do_write(8'h00, 32'h00000030);
        @(negedge clk);
        chk({nand_ale, nand_cle, nand_ce} == 3'b011, "R6 cle ce",
            {29'd0, nand_ale, nand_cle, nand_ce}, 32'h3);

        // R7 clock-edge events: stored bit 1 is 0
        do_write(8'h40, 32'h00000012);   // rising, sdo 1
        @(negedge clk);
        chk(sns_edge == 1'b0, "R7 pulse ends", 32'(sns_edge), 32'h0);
        do_write(8'h40, 32'h00000002);   // unchanged, no event
        do_write(8'h40, 32'h00000000);   // falling, sdo 0
        do_write(8'h48, 32'h00000002);   // other register, no event
        do_read(8'h40, 1'b0, 1'b0, 32'h0, "R8 pd_dout");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule